// File: doc/BRIEF.md
# CRC-CCITT Block Check Unit

This unit generates and verifies a 16-bit block check over blocks of data bytes. It uses the generator polynomial x^16 + x^12 + x^5 + 1. The block length is programmable from 1 to 64 data bytes, and every block is followed by two check bytes. Only data characters enter the calculation. The serial framing bits (start, stop and wakeup) are removed before bytes reach this unit.

Every block takes the programmed number of data strobes followed by two check strobes.

- **Transmit mode:** the unit accumulates the CRC over the data strobes. It then presents the high check byte, followed by the low check byte, on `checkByte`. The sending logic pulses `byteValid` once for each check byte as it consumes it.
- **Receive mode:** the two check strobes carry the received check bytes, which run through the CRC together with the data. A result other than zero is reported as an error.

The CRC register is preset to 0xFFFF at the start of every block. The byte counter clears by itself, so blocks can follow each other with no idle cycle between them.

Top module: `crcBlockUnit`

## Requirements
- R1: After reset, `blockDone`, `crcErr` and `checkValid` are 0.
- R2: The CRC is preset to 0xFFFF and updated once per accepted data strobe, MSB first, with polynomial 0x1021 and no final inversion. For the nine ASCII bytes "123456789" the check value is 0x29B1.
- R3: In transmit mode (`txMode`=1), `checkValid` is 1 once the last data byte has been accepted. `checkByte` first shows bits 15:8 of the CRC, then bits 7:0 after the first check strobe.
- R4: `blockDone` is a one-cycle pulse in the cycle after the second check strobe. A block is exactly length+2 strobes.
- R5: In receive mode (`txMode`=0), `crcErr` pulses together with `blockDone` only when the CRC over the data and both check bytes is not zero. `crcErr` never pulses in transmit mode.
- R6: A `blockLen` value of 0 means 64 data bytes, and a value of 1 gives a one-byte block.
- R7: The counter and the CRC return to their start values after each block. A strobe in the cycle right after a block's last strobe begins a new block with a 0xFFFF preset.
- R8: While `enable` is 0, strobes are ignored and the block restarts from its beginning, with the CRC preset again.
- R9: In transmit mode, `byteData` during the check strobes is ignored and does not change the low check byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Unit enable; 0 restarts the block |
| txMode | input | 1 | 1 = generate check bytes, 0 = verify |
| blockLen | input | 6 | Data bytes per block (0 means 64) |
| byteValid | input | 1 | One byte accepted or consumed this cycle |
| byteData | input | 8 | Data or received check byte |
| checkByte | output | 8 | Check byte to transmit (high byte, then low byte) |
| checkValid | output | 1 | `checkByte` is meaningful (transmit check phase) |
| blockDone | output | 1 | One-cycle pulse after a block completes |
| crcErr | output | 1 | One-cycle pulse on a receive CRC mismatch |

## Verification
The end of one block and the start of the next can fall in the same cycle. In that cycle, the completion pulse of the old block is raised while the first data byte of the new block is absorbed into a CRC that has just been preset. The bench provokes this by holding `byteValid` high across the boundary between two receive blocks, the second of which is corrupted. It judges the result by checking two things: the first block finishes clean, and the second reports exactly one error, with a CRC that is unaffected by the first block's residue.

// File: rtl/crcBlockPkg.sv
package crcBlockPkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef struct packed {
    logic preset;  // load the start value into the CRC register
    logic absorb;  // fold the current byte into the CRC register
    logic selLo;   // present the low check byte instead of the high one
  } ctrlStrobes_t;

  // One byte through the shift register, most significant bit first.
  function automatic logic [CRC_W-1:0] crcStep(
    input logic [CRC_W-1:0]  cur,
    input logic [BYTE_W-1:0] dat,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = cur;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ dat[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ poly;
    end
    return acc;
  endfunction

endpackage

// File: rtl/crcBlockCtrl.sv
module crcBlockCtrl
  import crcBlockPkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int LEN_W  = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             txMode,
  input  logic [LEN_W-1:0] blockLen,
  input  logic             byteValid,
  input  logic             residueZero,
  output ctrlStrobes_t     strobes,
  output logic             checkValid,
  output logic             blockDone,
  output logic             crcErr
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] effLen;
  logic             accept;
  logic             inCheck;
  logic             lastByte;

  // A length field of zero selects the largest block.
  assign effLen   = (blockLen == '0) ? CNT_W'(MAX_LEN) : CNT_W'(blockLen);
  assign accept   = enable && byteValid;
  assign inCheck  = cntQ >= effLen;
  assign lastByte = accept && (cntQ == effLen + CNT_W'(1));

  always_comb begin
    strobes.preset = !enable || lastByte;
    strobes.absorb = accept && !(txMode && inCheck);
    strobes.selLo  = cntQ != effLen;
  end

  assign checkValid = enable && txMode && inCheck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (!enable || lastByte) begin
      cntQ <= '0;
    end else if (accept) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockDone <= 1'b0;
      crcErr    <= 1'b0;
    end else begin
      blockDone <= lastByte;
      crcErr    <= lastByte && !txMode && !residueZero;
    end
  end

  // R4: completion is a single-cycle pulse (a block needs at least three strobes)
  a_r4_done_single : assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !blockDone);

  // R5: an error is only reported alongside block completion
  a_r5_err_with_done : assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> blockDone);

  // R5: no error in transmit mode
  a_r5_err_rx_only : assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> !$past(txMode));

  // R6: the counter never runs past the last check strobe
  a_r6_count_bound : assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(MAX_LEN + 1));

  // R8: disabling restarts the block and suppresses completion
  a_r8_disabled_idle : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (cntQ == '0) && !blockDone);

endmodule

// File: rtl/crcBlockDatapath.sv
module crcBlockDatapath
  import crcBlockPkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] byteData,
  output logic              residueZero,
  output logic [BYTE_W-1:0] checkByte
);

  localparam int HALF = CRC_W / 2;

  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] crcNext;

  assign crcNext     = crcStep(crcQ, byteData, POLY);
  assign residueZero = (crcNext == '0);
  assign checkByte   = strobes.selLo ? crcQ[HALF-1:0] : crcQ[CRC_W-1:HALF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ <= INIT;
    end else if (strobes.preset) begin
      crcQ <= INIT;
    end else if (strobes.absorb) begin
      crcQ <= crcNext;
    end
  end

  // R7: a preset request leaves the start value in the register
  a_r7_preset_loads : assert property (@(posedge clk) disable iff (!rstN)
    strobes.preset |=> crcQ == INIT);

  // R9: with no absorb and no preset the register holds its value
  a_r9_hold : assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.preset && !strobes.absorb) |=> $stable(crcQ));

endmodule

// File: rtl/crcBlockUnit.sv
module crcBlockUnit
  import crcBlockPkg::*;
#(
  parameter int               MAX_LEN = 64,
  parameter logic [CRC_W-1:0] POLY    = 16'h1021,
  parameter logic [CRC_W-1:0] INIT    = 16'hFFFF,
  localparam int              LEN_W   = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              txMode,
  input  logic [LEN_W-1:0]  blockLen,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic [BYTE_W-1:0] checkByte,
  output logic              checkValid,
  output logic              blockDone,
  output logic              crcErr
);

  ctrlStrobes_t strobes;
  logic         residueZero;

  crcBlockCtrl #(.MAX_LEN(MAX_LEN)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .txMode     (txMode),
    .blockLen   (blockLen),
    .byteValid  (byteValid),
    .residueZero(residueZero),
    .strobes    (strobes),
    .checkValid (checkValid),
    .blockDone  (blockDone),
    .crcErr     (crcErr)
  );

  crcBlockDatapath #(.POLY(POLY), .INIT(INIT)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .byteData   (byteData),
    .residueZero(residueZero),
    .checkByte  (checkByte)
  );

  // R1: status outputs are quiet right after reset
  a_r1_quiet_after_reset : assert property (@(posedge clk)
    $rose(rstN) |-> !blockDone && !crcErr);

endmodule

// File: tb/tb_crcBlockUnit.sv
module tb_crcBlockUnit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       txMode = 1'b0;
  logic [5:0] blockLen = '0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic [7:0] checkByte;
  logic       checkValid, blockDone, crcErr;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  bit  lastDone, lastErr;
  logic [7:0] dat [64];

  always #4 clk = ~clk;

  crcBlockUnit dut (
    .clk(clk), .rstN(rstN), .enable(enable), .txMode(txMode),
    .blockLen(blockLen), .byteValid(byteValid), .byteData(byteData),
    .checkByte(checkByte), .checkValid(checkValid),
    .blockDone(blockDone), .crcErr(crcErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic top = c[15] ^ dat[i][b];
        c = c << 1;
        if (top) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  function automatic void fill(input int n, input int seed);
    for (int i = 0; i < n; i++) dat[i] = 8'((i * 37 + seed * 11 + 3) & 255);
  endfunction

  // Called at a falling edge; drives a strobe and samples the next falling edge.
  task automatic strobe(input logic [7:0] d);
    byteValid = 1'b1;
    byteData  = d;
    @(negedge clk);
    lastDone = blockDone;
    lastErr  = crcErr;
  endtask

  task automatic idle();
    byteValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic runTx(input int lenField, input logic [15:0] expCrc, input string tag);
    int n = (lenField == 0) ? 64 : lenField;
    txMode = 1'b1;
    blockLen = 6'(lenField);
    for (int i = 0; i < n; i++) strobe(dat[i]);
    check(checkValid == 1'b1, {tag, " R3 checkValid"}, checkValid, 1);
    check(checkByte == expCrc[15:8], {tag, " R2 R3 high byte"}, checkByte, expCrc[15:8]);
    strobe(8'hA5);  // R9: data ignored on check strobes
    check(checkByte == expCrc[7:0], {tag, " R3 R9 low byte"}, checkByte, expCrc[7:0]);
    check(lastDone == 1'b0, {tag, " R4 no early done"}, lastDone, 0);
    strobe(8'h3C);
    check(lastDone == 1'b1, {tag, " R4 done pulse"}, lastDone, 1);
    check(lastErr == 1'b0, {tag, " R5 no err in tx"}, lastErr, 0);
    idle();
    check(blockDone == 1'b0, {tag, " R4 done one cycle"}, blockDone, 0);
  endtask

  // Receive block; optionally corrupts the low check byte. Leaves byteValid high.
  task automatic rxBlock(input int lenField, input bit corrupt, input string tag);
    int n = (lenField == 0) ? 64 : lenField;
    logic [15:0] c = refCrc(n);
    txMode = 1'b0;
    blockLen = 6'(lenField);
    for (int i = 0; i < n; i++) strobe(dat[i]);
    strobe(c[15:8]);
    check(lastDone == 1'b0, {tag, " R4 no early done"}, lastDone, 0);
    strobe(corrupt ? (c[7:0] ^ 8'h01) : c[7:0]);
    check(lastDone == 1'b1, {tag, " R4 done"}, lastDone, 1);
    check(lastErr == corrupt, {tag, " R5 err flag"}, lastErr, corrupt);
  endtask

  task automatic testReset();
    check(blockDone == 1'b0, "R1 blockDone", blockDone, 0);
    check(crcErr == 1'b0, "R1 crcErr", crcErr, 0);
    check(checkValid == 1'b0, "R1 checkValid", checkValid, 0);
  endtask

  task automatic testKnownVector();
    string s = "123456789";
    for (int i = 0; i < 9; i++) dat[i] = s[i];
    runTx(9, 16'h29B1, "known R2");
  endtask

  task automatic testTxPatterns();
    fill(5, 1);  runTx(5, refCrc(5), "tx5 R2");
    fill(1, 2);  runTx(1, refCrc(1), "tx1 R6");
    fill(64, 3); runTx(0, refCrc(64), "tx64 R6");
  endtask

  task automatic testRx();
    fill(7, 4);  rxBlock(7, 1'b0, "rx7 R5");  idle();
    fill(7, 5);  rxBlock(7, 1'b1, "rx7bad R5"); idle();
    check(crcErr == 1'b0, "R5 err one cycle", crcErr, 0);
    fill(1, 6);  rxBlock(1, 1'b0, "rx1 R6"); idle();
    fill(64, 7); rxBlock(0, 1'b0, "rx64 R6"); idle();
  endtask

  task automatic testBackToBack();
    fill(2, 8);
    rxBlock(2, 1'b0, "b2b first R7");
    rxBlock(2, 1'b1, "b2b second R7");
    rxBlock(2, 1'b0, "b2b third R7");
    idle();
  endtask

  task automatic testEnable();
    fill(6, 9);
    txMode = 1'b1;
    blockLen = 6'd6;
    strobe(8'h11); strobe(8'h22); strobe(8'h33);
    enable = 1'b0;
    strobe(8'h44);
    strobe(8'h55);
    check(checkValid == 1'b0, "R8 no checkValid while disabled", checkValid, 0);
    check(lastDone == 1'b0, "R8 no done while disabled", lastDone, 0);
    idle();
    enable = 1'b1;
    runTx(6, refCrc(6), "after enable R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    enable = 1'b1;
    testKnownVector();
    testTxPatterns();
    testRx();
    testBackToBack();
    testEnable();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule